// File: doc/BRIEF.md
# Four-Channel PWM Generator

This block produces four pulse-width-modulated outputs from one system clock, each configured through a small register file. The register file sits on a synchronous word-addressed read/write bus. The clock is divided in two stages. Two shared first-stage dividers each serve a pair of channels. Each channel then applies its own power-of-two selector to the ticks of its pair's divider. The resulting channel tick steps a down-counter. That counter runs from a programmed period value to zero. It either reloads or stops at the end, depending on a per-channel mode bit.

Each channel compares its counter against a compare value. The output is asserted while the counter is at or below that value. The compare value is taken into use only when the counter loads, so a duty change never cuts a period short or stretches it. A per-channel invert bit flips the output polarity. When a channel is disabled, or has finished a one-shot run, it drives the level that its invert bit selects. Software usually programs a disabled channel as inverted, so the idle output rests high.

Top module: `quad_pwm_gen`

## Requirements
- R1: After reset every output is 0, every register reads 0, and all channels are disabled.
- R2: The bus uses word addresses. Address 0 is the first-stage divider, 1 is the selector and 2 is the control word. For channel k, address 3+3k is the period, 4+3k is the compare value and 5+3k is the live counter, which is read-only. For channel k the control word holds enable at bit e(k) (e = 0, 8, 12, 16), invert at e(k)+2 and mode at e(k)+3. All other control bits read back as 0, and period and compare keep only their low CNT_W bits.
- R3: Divider field bits 7:0 serve channels 0 and 1, and bits 15:8 serve channels 2 and 3. A field value F>0 gives one tick every F+1 clocks. F=0 stops the ticks, which freezes the counter and the output of both channels of that pair.
- R4: Selector nibble k (bits 4k+3:4k) sets channel k's second stage. Values 0, 1, 2 and 3 divide the pair tick by 2, 4, 8 and 16. The value 4 and every value above it divide by 1.
- R5: When enable rises, the counter loads the period value P. It then decrements on each channel tick, and a full period lasts P+1 channel ticks.
- R6: The uninverted output is high while the counter is at or below the latched compare value C. It is high for min(C,P)+1 ticks of each period, so C>=P gives full duty.
- R7: With mode=1 the counter reloads P after the tick at 0. With mode=0 the channel stops after that tick: the counter stays at 0 and the output returns to its idle level. Clearing enable and setting it again restarts the run.
- R8: The compare value is latched only at enable and at reload. A compare write in the middle of a period does not change the output until the next period.
- R9: With invert=1 the output is the complement of the uninverted waveform.
- R10: A disabled channel drives its invert bit, within two clocks of enable being cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one clock after the address |
| pwm_out | output | 4 | Registered PWM outputs, bit k for channel k |

## Verification
The bench builds the block with its defaults: CNT_W=8 and ADDR_W=5. With these, all four period, compare and counter registers fall within the address space, and narrow writes can be seen to truncate at 8 bits. Small periods (3 to 13 ticks) combined with first-stage ratios of 2 to 16 keep each full period within a few hundred clocks. This allows exact high-time counts over whole periods for every selector ratio, as well as one-shot runs and mid-period compare writes.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int NCH = 4;

  // control-word bit of each channel's enable; invert and mode follow at +2, +3
  function automatic int en_bit(input int ch);
    return (ch == 0) ? 0 : (4 + 4 * ch);
  endfunction

  function automatic logic [31:0] ctrl_mask();
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < NCH; k++) begin
      m[en_bit(k)]     = 1'b1;
      m[en_bit(k) + 2] = 1'b1;
      m[en_bit(k) + 3] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [31:0] CTRL_MASK = ctrl_mask();
endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 bus_wr,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [31:0]                          bus_wdata,
  output logic [31:0]                          bus_rdata,
  output logic [15:0]                          pre_q,
  output logic [15:0]                          sel_q,
  output logic [31:0]                          ctrl_q,
  output logic [qpwm_pkg::NCH-1:0][CNT_W-1:0]  period_q,
  output logic [qpwm_pkg::NCH-1:0][CNT_W-1:0]  cmp_q,
  input  logic [qpwm_pkg::NCH-1:0][CNT_W-1:0]  live_cnt
);
  import qpwm_pkg::*;

  localparam int PER_BASE = 3;
  localparam int STRIDE   = 3;

  logic [31:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      sel_q    <= '0;
      ctrl_q   <= '0;
      period_q <= '0;
      cmp_q    <= '0;
    end else if (bus_wr) begin
      if (int'(bus_addr) == 0) pre_q  <= bus_wdata[15:0];
      if (int'(bus_addr) == 1) sel_q  <= bus_wdata[15:0];
      if (int'(bus_addr) == 2) ctrl_q <= bus_wdata & CTRL_MASK;
      for (int k = 0; k < NCH; k++) begin
        if (int'(bus_addr) == PER_BASE + STRIDE * k)     period_q[k] <= bus_wdata[CNT_W-1:0];
        if (int'(bus_addr) == PER_BASE + STRIDE * k + 1) cmp_q[k]    <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (int'(bus_addr))
      0:       rd_mux = {16'h0, pre_q};
      1:       rd_mux = {16'h0, sel_q};
      2:       rd_mux = ctrl_q;
      default: rd_mux = '0;
    endcase
    for (int k = 0; k < NCH; k++) begin
      if (int'(bus_addr) == PER_BASE + STRIDE * k)     rd_mux = 32'(period_q[k]);
      if (int'(bus_addr) == PER_BASE + STRIDE * k + 1) rd_mux = 32'(cmp_q[k]);
      if (int'(bus_addr) == PER_BASE + STRIDE * k + 2) rd_mux = 32'(live_cnt[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/qpwm_prescale.sv
module qpwm_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || div == '0)   cnt <= '0;
    else if (cnt >= div)    cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign tick = (div != '0) && (cnt == div);

  // a nonzero ratio makes the tick period at least two clocks (R3)
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pre_tick,
  input  logic [3:0]       sel,
  input  logic             en,
  input  logic             inv,
  input  logic             mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_val,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt, cmp_act;
  logic [3:0]       sdiv, lim;
  logic             run, en_q, en_rise, ch_tick, wrap;

  always_comb begin
    case (sel)
      4'd0:    lim = 4'd1;
      4'd1:    lim = 4'd3;
      4'd2:    lim = 4'd7;
      4'd3:    lim = 4'd15;
      default: lim = 4'd0;
    endcase
  end

  assign en_rise = en && !en_q;
  assign ch_tick = run && pre_tick && (sdiv >= lim);
  assign wrap    = ch_tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cmp_act <= '0;
      sdiv    <= '0;
      run     <= 1'b0;
      en_q    <= 1'b0;
      pwm     <= 1'b0;
    end else begin
      en_q <= en;
      if (!en) begin
        run  <= 1'b0;
        sdiv <= '0;
      end else if (en_rise) begin
        cnt     <= period;
        cmp_act <= cmp;
        run     <= 1'b1;
        sdiv    <= '0;
      end else if (run && pre_tick) begin
        sdiv <= (sdiv >= lim) ? 4'd0 : sdiv + 4'd1;
        if (ch_tick) begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (mode) begin
            cnt     <= period;
            cmp_act <= cmp;
          end else begin
            run <= 1'b0;
          end
        end
      end
      pwm <= (run && (cnt <= cmp_act)) ^ inv;
    end
  end

  assign cnt_val = cnt;

  // compare is taken into use only at enable or reload (R8)
  assert_cmp_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(en_rise || wrap) |=> $stable(cmp_act));

  // a running counter steps down by one per channel tick (R5)
  assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
    (en && !en_rise && ch_tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // an idle channel drives its invert level (R10)
  assert_idle_level_R10: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm == $past(inv)));

  // one-shot run ends with the counter parked at zero (R7)
  assert_oneshot_park_R7: assert property (@(posedge clk) disable iff (rst)
    (en && !en_rise && wrap && !mode) |=> (!run && cnt == '0));
endmodule

// File: rtl/quad_pwm_gen.sv
module quad_pwm_gen #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [3:0]        pwm_out
);
  import qpwm_pkg::*;

  localparam int NPAIR = NCH / 2;

  logic [15:0]                  pre_q, sel_q;
  logic [31:0]                  ctrl_q;
  logic [NCH-1:0][CNT_W-1:0]    period_q, cmp_q, live_cnt;
  logic [NPAIR-1:0]             pair_tick;

  qpwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pre_q(pre_q),
    .sel_q(sel_q), .ctrl_q(ctrl_q), .period_q(period_q), .cmp_q(cmp_q),
    .live_cnt(live_cnt)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pre
    qpwm_prescale #(.DIV_W(8)) pre_i (
      .clk(clk), .rst(rst), .div(pre_q[8*p +: 8]), .tick(pair_tick[p])
    );
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int EB = en_bit(g);
    qpwm_channel #(.CNT_W(CNT_W)) ch_i (
      .clk(clk), .rst(rst), .pre_tick(pair_tick[g / 2]),
      .sel(sel_q[4*g +: 4]), .en(ctrl_q[EB]), .inv(ctrl_q[EB + 2]),
      .mode(ctrl_q[EB + 3]), .period(period_q[g]), .cmp(cmp_q[g]),
      .cnt_val(live_cnt[g]), .pwm(pwm_out[g])
    );
  end
endmodule

// File: tb/quad_pwm_gen_tb_top.sv
`timescale 1ns/1ps
module quad_pwm_gen_tb_top;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [3:0]    pwm_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] sh_pre = 0, sh_sel = 0, sh_ctrl = 0;

  always #2.5 clk = ~clk;

  quad_pwm_gen #(.CNT_W(8), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int enb(input int ch);
    return (ch == 0) ? 0 : 4 + 4 * ch;
  endfunction

  function automatic int sel_div(input int s);
    return (s < 4) ? (2 << s) : 1;
  endfunction

  function automatic int exp_high(input int p, input int c, input int t, input int per, input bit inv);
    int h;
    h = per * (((c < p) ? c : p) + 1) * t;
    return inv ? per * (p + 1) * t - h : h;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_addr = a[AW-1:0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); bus_addr = a[AW-1:0];
    @(negedge clk); v = int'(bus_rdata);
  endtask

  task automatic meas(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); hi += int'(pwm_out[ch]); end
  endtask

  task automatic set_pre(input int pair, input int f);
    sh_pre[8*pair +: 8] = f[7:0]; wr(0, sh_pre);
  endtask

  task automatic set_sel(input int ch, input int s);
    sh_sel[4*ch +: 4] = s[3:0]; wr(1, sh_sel);
  endtask

  task automatic set_ctrl(input int ch, input bit en, input bit inv, input bit mode);
    sh_ctrl[enb(ch)] = en; sh_ctrl[enb(ch)+2] = inv; sh_ctrl[enb(ch)+3] = mode;
    wr(2, sh_ctrl);
  endtask

  // configure, start, settle, then count high clocks over two whole periods
  task automatic duty_run(input string req, input int ch, input int f, input int s,
                          input int p, input int c, input bit inv);
    int t, hi;
    set_ctrl(ch, 0, inv, 1);
    set_pre(ch / 2, f); set_sel(ch, s);
    wr(3 + 3*ch, p); wr(4 + 3*ch, c);
    set_ctrl(ch, 1, inv, 1);
    t = (f + 1) * sel_div(s);
    repeat (2 * (p + 1) * t + 10) @(negedge clk);
    meas(ch, 2 * (p + 1) * t, hi);
    chk(req, hi, exp_high(p, c, t, 2, inv));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, hi, v2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_out", int'(pwm_out), 0);
    rd(2, v); chk("R1 ctrl", v, 0);
    rd(7, v); chk("R1 cmp ch1", v, 0);
    rd(0, v); chk("R1 divider", v, 0);

    // R2 control mask and width truncation
    wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R2 ctrl readback", v, 32'h000D_DD0D);
    wr(2, 0);
    wr(12, 32'hABCD); rd(12, v); chk("R2 period ch3 trunc", v, 32'hCD);
    wr(12, 0);

    // R5/R6 basic duty, ch0, divider 2, selector /1
    duty_run("R6 duty C<P", 0, 1, 4, 9, 3, 0);
    duty_run("R9 inverted", 0, 1, 4, 9, 3, 1);
    duty_run("R6 full duty C=P", 0, 1, 4, 9, 9, 0);
    duty_run("R6 full duty C>P", 0, 1, 4, 9, 200, 0);
    duty_run("R6 zero compare", 0, 1, 4, 9, 0, 0);
    duty_run("R4 selector /2", 0, 1, 0, 9, 3, 0);
    duty_run("R4 selector 7 is /1", 0, 1, 7, 9, 3, 0);
    duty_run("R3 upper field for ch2", 2, 3, 4, 4, 1, 0);

    // R3 zero divider freezes ch0
    duty_run("R3 pre-freeze duty", 0, 1, 4, 9, 3, 0);
    set_pre(0, 0);
    repeat (3) @(negedge clk);
    rd(5, v);
    v2 = int'(pwm_out[0]);
    meas(0, 60, hi);
    chk("R3 frozen output", hi, 60 * v2);
    rd(5, hi); chk("R3 frozen counter", hi, v);
    set_pre(0, 1);
    set_ctrl(0, 0, 0, 1);

    // R5 counter loads period on enable; /16 keeps it there a while
    set_pre(1, 15); set_sel(2, 3); wr(9, 4);
    set_ctrl(2, 0, 0, 1); set_ctrl(2, 1, 0, 1);
    rd(11, v); chk("R5 load period", v, 4);
    set_ctrl(2, 0, 0, 1);

    // R7 one-shot on ch1
    set_sel(1, 4); wr(6, 9); wr(7, 3);
    set_ctrl(1, 0, 0, 0); set_ctrl(1, 1, 0, 0);
    meas(1, 200, hi); chk("R7 one-shot high clocks", hi, 8);
    rd(8, v); chk("R7 parked counter", v, 0);
    chk("R7 idle after run", int'(pwm_out[1]), 0);
    set_ctrl(1, 0, 0, 0); set_ctrl(1, 1, 0, 0);
    meas(1, 200, hi); chk("R7 restart", hi, 8);
    set_ctrl(1, 0, 0, 0);

    // R8 mid-period compare write on ch3 (T = 16)
    set_pre(1, 15); set_sel(3, 4); wr(12, 7); wr(13, 2);
    set_ctrl(3, 0, 0, 1); set_ctrl(3, 1, 0, 1);
    repeat (2 * 8 * 16 + 10) @(negedge clk);
    v = -1;
    for (int i = 0; i < 300 && v != 6; i++) rd(14, v);
    chk("R8 counter seen at 6", v, 6);
    wr(13, 6);
    repeat (2) @(negedge clk);
    chk("R8 no mid-period effect", int'(pwm_out[3]), 0);
    repeat (2 * 8 * 16 + 10) @(negedge clk);
    meas(3, 2 * 8 * 16, hi); chk("R8 new compare next period", hi, 2 * 7 * 16);

    // R10 disabled level follows invert
    duty_run("R10 pre-disable duty", 0, 1, 4, 5, 2, 1);
    set_ctrl(0, 0, 1, 1); repeat (3) @(negedge clk);
    meas(0, 30, hi); chk("R10 disabled inverted", hi, 30);
    set_ctrl(0, 0, 0, 1); repeat (3) @(negedge clk);
    meas(0, 30, hi); chk("R10 disabled plain", hi, 0);

    // random trials for R6/R9/R4
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) begin
      int ch, f, s, p, c, sv;
      ch = $urandom % 4;
      f  = 1 + $urandom % 3;
      sv = $urandom % 4;
      s  = (sv == 0) ? 0 : (sv == 1) ? 1 : (sv == 2) ? 4 : 9;
      p  = 2 + $urandom % 11;
      c  = $urandom % (p + 3);
      duty_run("R6 R9 random", ch, f, s, p, c, bit'($urandom % 2));
      set_ctrl(ch, 0, 0, 1);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule